// File: doc/BRIEF.md
# Two-Strobe Up/Down Binary Counter

This block is a small binary counter, four bits wide by default. Instead of one clock and a direction pin, it has two count strobes: one to count up and one to count down. Both strobes are level inputs that the block samples on a single system clock. A count step happens on a low-to-high transition of a strobe. That step only counts while the opposite strobe rests high. If both strobes rise in the same cycle, the block takes no step.

A high-active clear forces the count to zero. A low-active load copies a preset word into the count. The priority is clear, then load, then counting. All count bits change together on one system clock edge.

Two active-low cascade outputs make chaining possible:
- The carry output goes low while the up strobe is low and the count sits at its top value.
- The borrow output goes low while the down strobe is low and the count is zero.

Each pulse is therefore exactly as wide as the strobe's low phase. Wiring carry to the next stage's up strobe, and borrow to its down strobe, makes a wider counter. The carry-out rises on the same sample as the strobe that causes the wrap, so the next stage steps in the same clock cycle.

The strobes, clear and load are plain control pins. There is no data stream and no handshake, so no back-pressure applies.

Top module: `dual_strobe_counter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it goes high with both strobes high, count is 0, carry_n is 1 and borrow_n is 1.
- R2: A rising edge of up_strobe while down_strobe is high adds 1 to count on that clock edge. From the top value (all ones) it wraps to 0.
- R3: A rising edge of down_strobe while up_strobe is high subtracts 1 from count on that clock edge. From 0 it wraps to all ones.
- R4: clear high sets count to 0 on the next clock edge, whatever load_n and the strobes do.
- R5: load_n low (with clear low) copies preset into count on the next clock edge. Any strobe edge in that cycle is ignored.
- R6: If up_strobe and down_strobe both rise in the same clock cycle, count does not change.
- R7: A rising edge of one strobe while the other strobe is low leaves count unchanged. A falling strobe edge never changes count.
- R8: carry_n is 0 exactly when count is all ones and up_strobe is low; otherwise it is 1. It follows up_strobe without a clock delay.
- R9: borrow_n is 0 exactly when count is 0 and down_strobe is low; otherwise it is 1. It follows down_strobe without a clock delay.
- R10: Two instances chained (carry_n to the upper up_strobe, borrow_n to the upper down_strobe, clear and load_n shared) count as one counter of twice the width, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low system reset |
| up_strobe | input | 1 | Count-up strobe; counts on a rising edge, idles high |
| down_strobe | input | 1 | Count-down strobe; counts on a rising edge, idles high |
| clear | input | 1 | Active-high clear, highest priority |
| load_n | input | 1 | Active-low parallel load of preset |
| preset | input | WIDTH | Word copied into the count during load |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low overflow pulse for cascading up |
| borrow_n | output | 1 | Active-low underflow pulse for cascading down |

## Verification
Two functions can land in the same clock edge in several ways: a count edge against a load, a count edge against a clear, an up edge against a down edge, and the lower stage's wrap against the upper stage's step in a chained pair. The bench drives each pairing on purpose. Examples are a preset held low while an up strobe rises, and both strobes released together. A reference model, written from the priority and direction rules, predicts count, carry_n and borrow_n for every cycle. The chained pair is judged by the combined count across the carry and borrow boundaries.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int unsigned STB_UP = 0;
  localparam int unsigned STB_DN = 1;
  localparam int unsigned NUM_STB = 2;
endpackage

// File: rtl/dsc_edge_detect.sv
module dsc_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // strobes idle high, so the history starts high to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= level[i];
    end
    assign rise[i] = level[i] & ~prev_q[i];

    a_r7_no_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!level[i]) |-> !rise[i]);
  end
endmodule

// File: rtl/dsc_steer.sv
module dsc_steer
  import dsc_pkg::*;
(
  input  logic  up_rise,
  input  logic  dn_rise,
  input  logic  up_level,
  input  logic  dn_level,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (up_rise && !dn_rise && dn_level)      step = STEP_UP;
    else if (dn_rise && !up_rise && up_level) step = STEP_DOWN;
  end
endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  step_e            step,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (clear)          count_d = '0;
    else if (!load_n)   count_d = preset;
    else begin
      unique case (step)
        STEP_UP:   count_d = count_q + ONE;
        STEP_DOWN: count_d = count_q - ONE;
        default:   count_d = count_q;
      endcase
    end
  end

  // every bit is written on the same edge: no ripple between bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(clear)) |-> (count_q == '0));

  a_r5_load_takes_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(!clear && !load_n)) |-> (count_q == $past(preset)));

  a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(!clear && load_n && step == STEP_UP && count_q == TOP))
      |-> (count_q == '0));

  a_r3_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(!clear && load_n && step == STEP_DOWN && count_q == '0))
      |-> (count_q == TOP));
endmodule

// File: rtl/dsc_cascade_out.sv
module dsc_cascade_out #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count,
  input  logic             up_level,
  input  logic             dn_level,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic at_top, at_zero;
  assign at_top  = (count == TOP);
  assign at_zero = (count == '0);

  // the pulses track the strobe levels directly, so their width matches
  assign carry_n  = ~(at_top  & ~up_level);
  assign borrow_n = ~(at_zero & ~dn_level);

  a_r8_carry_idle: assert property (@(posedge clk) disable iff (!rst_n)
    up_level |-> carry_n);

  a_r9_borrow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dn_level |-> borrow_n);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_strobe,
  input  logic             down_strobe,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic [NUM_STB-1:0] levels, rises;
  step_e              step;

  assign levels[STB_UP] = up_strobe;
  assign levels[STB_DN] = down_strobe;

  dsc_edge_detect #(.N(NUM_STB)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (levels),
    .rise  (rises)
  );

  dsc_steer u_steer (
    .up_rise  (rises[STB_UP]),
    .dn_rise  (rises[STB_DN]),
    .up_level (up_strobe),
    .dn_level (down_strobe),
    .step     (step)
  );

  dsc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .load_n (load_n),
    .preset (preset),
    .step   (step),
    .count  (count)
  );

  dsc_cascade_out #(.WIDTH(WIDTH)) u_casc (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .up_level (up_strobe),
    .dn_level (down_strobe),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  a_r6_both_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rises[STB_UP] && rises[STB_DN] && !clear && load_n) |=> $stable(count));

  a_r7_rise_other_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rises[STB_UP] && !down_strobe && !clear && load_n) |=> $stable(count));
endmodule

// File: tb/dual_strobe_counter_tb_top.sv
module dual_strobe_counter_tb_top;
  localparam int W = 4;
  localparam logic [W-1:0] TOPV = {W{1'b1}};

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n = 1'b0;
  logic up_s = 1'b1, dn_s = 1'b1, clr = 1'b0, ld_n = 1'b1;
  logic [W-1:0] pre_lo = '0, pre_hi = '0;
  logic [W-1:0] q_lo, q_hi;
  logic c_lo, b_lo, c_hi, b_hi;

  dual_strobe_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_strobe(up_s), .down_strobe(dn_s),
    .clear(clr), .load_n(ld_n), .preset(pre_lo),
    .count(q_lo), .carry_n(c_lo), .borrow_n(b_lo));

  // upper stage for R10: fed by the lower stage's cascade outputs
  dual_strobe_counter #(.WIDTH(W)) dut_hi (
    .clk(clk), .rst_n(rst_n), .up_strobe(c_lo), .down_strobe(b_lo),
    .clear(clr), .load_n(ld_n), .preset(pre_hi),
    .count(q_hi), .carry_n(c_hi), .borrow_n(b_hi));

  typedef struct {
    string        tag;
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    logic         cy;
    logic         bw;
  } exp_t;

  exp_t sb[$];
  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [W-1:0] m_lo = '0, m_hi = '0;
  logic p_up = 1'b1, p_dn = 1'b1, p_cl = 1'b1, p_bl = 1'b1;

  function automatic logic [W-1:0] nxt(input logic [W-1:0] v,
      input logic ur, input logic dr, input logic ul, input logic dl,
      input logic c, input logic ln, input logic [W-1:0] d);
    if (c)                    return '0;
    if (!ln)                  return d;
    if (ur && !dr && dl)      return v + 1'b1;
    if (dr && !ur && ul)      return v - 1'b1;
    return v;
  endfunction

  task automatic step(input logic up, input logic dn, input logic c,
                      input logic ln, input logic [W-1:0] dlo,
                      input logic [W-1:0] dhi, input string tag);
    logic cl, bl;
    exp_t e;
    @(negedge clk);
    up_s = up; dn_s = dn; clr = c; ld_n = ln; pre_lo = dlo; pre_hi = dhi;
    cl = !(m_lo == TOPV && !up);
    bl = !(m_lo == '0 && !dn);
    m_hi = nxt(m_hi, cl & ~p_cl, bl & ~p_bl, cl, bl, c, ln, dhi);
    m_lo = nxt(m_lo, up & ~p_up, dn & ~p_dn, up, dn, c, ln, dlo);
    p_up = up; p_dn = dn; p_cl = cl; p_bl = bl;
    e.tag = tag; e.lo = m_lo; e.hi = m_hi;
    e.cy = !(m_lo == TOPV && !up);
    e.bw = !(m_lo == '0 && !dn);
    sb.push_back(e);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_tests++;
        if (q_lo !== e.lo || q_hi !== e.hi || c_lo !== e.cy || b_lo !== e.bw) begin
          n_fail++;
          $display("FAIL %s: got lo=%0d hi=%0d carry_n=%b borrow_n=%b, expected lo=%0d hi=%0d carry_n=%b borrow_n=%b",
                   e.tag, q_lo, q_hi, c_lo, b_lo, e.lo, e.hi, e.cy, e.bw);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (q_lo !== '0 || c_lo !== 1'b1 || b_lo !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 in reset: got %0d/%b/%b, expected 0/1/1", q_lo, c_lo, b_lo);
    end
    rst_n = 1'b1;
    step(1, 1, 0, 1, 0, 0, "R1 after reset");

    // load lower=13, upper=0
    step(1, 1, 0, 0, 13, 0, "R5 load preset");
    step(1, 1, 0, 1, 0, 0, "R5 load released");
    // up pulses through the top value: carry pulse and cascade
    step(0, 1, 0, 1, 0, 0, "R7 falling up no count");
    step(1, 1, 0, 1, 0, 0, "R2 up to 14");
    step(0, 1, 0, 1, 0, 0, "R8 no carry below top");
    step(1, 1, 0, 1, 0, 0, "R2 up to 15");
    step(0, 1, 0, 1, 0, 0, "R8 carry low at top");
    step(0, 1, 0, 1, 0, 0, "R8 carry held low");
    step(1, 1, 0, 1, 0, 0, "R10 wrap carries into upper");
    // down through zero: borrow pulse and cascade
    step(1, 0, 0, 1, 0, 0, "R9 borrow low at zero");
    step(1, 1, 0, 1, 0, 0, "R10 wrap borrows from upper");
    step(1, 0, 0, 1, 0, 0, "R9 no borrow at 15");
    step(1, 1, 0, 1, 0, 0, "R3 down to 14");
    // both rise together
    step(0, 0, 0, 1, 0, 0, "R6 both low");
    step(1, 1, 0, 1, 0, 0, "R6 both rise hold");
    // rise with other held low
    step(1, 0, 0, 1, 0, 0, "R7 down low");
    step(0, 0, 0, 1, 0, 0, "R7 up low too");
    step(1, 0, 0, 1, 0, 0, "R7 up rise with down low");
    step(1, 1, 0, 1, 0, 0, "R3 down rise counts");
    // count edge during load
    step(0, 1, 0, 0, 5, 9, "R5 load with up low");
    step(1, 1, 0, 0, 5, 9, "R5 up edge ignored in load");
    step(1, 1, 0, 1, 0, 0, "R5 load done");
    // clear overrides load and count
    step(0, 1, 0, 1, 0, 0, "R4 setup");
    step(1, 1, 1, 0, 7, 7, "R4 clear beats load and count");
    step(1, 1, 0, 1, 0, 0, "R4 clear released");
    // down from zero wraps lower and borrows upper
    step(1, 0, 0, 1, 0, 0, "R9 borrow at zero");
    step(1, 1, 0, 1, 0, 0, "R3 wrap to top");
    // up run across the lower boundary several times
    for (int i = 0; i < 40; i++) begin
      step(0, 1, 0, 1, 0, 0, "R2 run low");
      step(1, 1, 0, 1, 0, 0, "R10 run up");
    end
    for (int i = 0; i < 24; i++) begin
      step(1, 0, 0, 1, 0, 0, "R3 run low");
      step(1, 1, 0, 1, 0, 0, "R10 run down");
    end
    repeat (3) @(posedge clk);
    #3;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule